// File: doc/BRIEF.md
# Run-Mode Clock Configuration with Override and System-Enable Divider

This block holds one 32-bit run-mode clock configuration word on a simple full-word register bus and turns it into the chip's effective clock controls. A second set of configuration fields, the older narrow form, arrives on input pins. A single override bit in the register chooses which of the two sets drives the outputs. When it is clear, the pin fields are used. When it is set, the register's own fields are used instead.

The selected divisor sets the rate of a system-clock enable pulse. The source ticks come from the PLL tick input, or from the oscillator tick input when the PLL is bypassed or powered down. These ticks are first halved and then divided by the divisor field value plus one. The register's divisor field is two bits wider than the legacy one, so the slowest rate is much lower. The effective oscillator select, bypass and power-down controls are also driven out for the clock generators that sit outside this block.

Top module: `clkcfg_ovr_top`

## Requirements
- R1: After reset, `rd_data` reads 0x0780_2810: override bit 31 = 0, divisor field 28:23 = 0x0F, power-down bit 13 = 1, bypass bit 11 = 1, source select 6:4 = 3'b001.
- R2: A word presented with `wr_en` high is captured at that clock edge, and it is visible on `rd_data` from the following cycle.
- R3: Only bits 31, 28:23, 13, 11 and 6:4 are stored (mask 0x9F80_2870). All other bits read as zero, and writing ones to them has no effect.
- R4: With bit 31 clear, `eff_oscsel`, `eff_bypass` and `eff_pwrdn` follow the legacy inputs. The divider uses `leg_div` zero-extended to 6 bits.
- R5: With bit 31 set, the effective controls come from the register: the divisor from 28:23, power-down from bit 13, bypass from bit 11 and source select from 6:4. The legacy inputs are ignored.
- R6: `sys_en` is a one-cycle pulse. With a steady source it repeats every 2×(N+1) source ticks, where N is the effective divisor.
- R7: The divider counts `pll_tick` when both the effective bypass and the effective power-down are low. Otherwise it counts `osc_tick`.
- R8: A new effective divisor is adopted only at a terminal count. The period in progress finishes with the old divisor.
- R9: The divisor ends map as follows: 0 gives one pulse per 2 ticks, 63 on the register path gives one per 128 ticks, and 15 on the legacy path gives one per 32 ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Full-word register write strobe |
| wr_data | input | 32 | Register write data |
| rd_data | output | 32 | Stored register word, reserved bits zero |
| leg_div | input | 4 | Legacy divisor field |
| leg_bypass | input | 1 | Legacy PLL bypass |
| leg_pwrdn | input | 1 | Legacy PLL power-down |
| leg_oscsel | input | 3 | Legacy oscillator source select |
| pll_tick | input | 1 | One-cycle tick per PLL output period |
| osc_tick | input | 1 | One-cycle tick per oscillator period |
| eff_oscsel | output | 3 | Effective oscillator source select |
| eff_bypass | output | 1 | Effective PLL bypass |
| eff_pwrdn | output | 1 | Effective PLL power-down |
| sys_en | output | 1 | System clock enable pulse |

## Verification
A corrupted stored field shows up on `rd_data` in the cycle after the write, and with the override set it also shows on the effective control outputs in the same cycle. A wrong divider count, prescale phase or latched divisor does not show until the next `sys_en` pulse, which can be up to 256 cycles away when the oscillator path runs at the slowest divisor. For that reason the bench discards one pulse after each change and then measures a whole period. A divisor adopted too early appears as a first period after a change that is shorter than the old divisor's period.

// File: rtl/clkcfg_pkg.sv
package clkcfg_pkg;

    localparam int REG_W      = 32;
    localparam int LEG_DIV_W  = 4;
    localparam int DIV_W      = LEG_DIV_W + 2;
    localparam int OSC_W      = 3;

    localparam int OVR_BIT    = 31;
    localparam int DIV_LSB    = 23;
    localparam int DIV_MSB    = DIV_LSB + DIV_W - 1;
    localparam int PD_BIT     = 13;
    localparam int BYP_BIT    = 11;
    localparam int OSC_LSB    = 4;
    localparam int OSC_MSB    = OSC_LSB + OSC_W - 1;

    localparam logic [REG_W-1:0] RESET_WORD = 32'h0780_2810;

    typedef struct packed {
        logic [DIV_W-1:0] div;
        logic             pwrdn;
        logic             bypass;
        logic [OSC_W-1:0] oscsel;
    } clk_cfg_t;

    function automatic logic [REG_W-1:0] field_mask();
        logic [REG_W-1:0] m;
        m = '0;
        m[OVR_BIT] = 1'b1;
        m[DIV_MSB:DIV_LSB] = '1;
        m[PD_BIT] = 1'b1;
        m[BYP_BIT] = 1'b1;
        m[OSC_MSB:OSC_LSB] = '1;
        return m;
    endfunction

    function automatic clk_cfg_t decode_word(input logic [REG_W-1:0] w);
        clk_cfg_t c;
        c.div    = w[DIV_MSB:DIV_LSB];
        c.pwrdn  = w[PD_BIT];
        c.bypass = w[BYP_BIT];
        c.oscsel = w[OSC_MSB:OSC_LSB];
        return c;
    endfunction

    function automatic clk_cfg_t widen_legacy(
        input logic [LEG_DIV_W-1:0] d,
        input logic                 byp,
        input logic                 pd,
        input logic [OSC_W-1:0]     osc
    );
        clk_cfg_t c;
        c.div    = {{(DIV_W-LEG_DIV_W){1'b0}}, d};
        c.pwrdn  = pd;
        c.bypass = byp;
        c.oscsel = osc;
        return c;
    endfunction

endpackage

// File: rtl/clkcfg_regfile.sv
module clkcfg_regfile
    import clkcfg_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    output logic [REG_W-1:0] word_q
);
    localparam logic [REG_W-1:0] MASK = field_mask();

    logic [REG_W-1:0] store_q;

    // One flop per writable bit; reserved positions are constant zero.
    for (genvar b = 0; b < REG_W; b++) begin : g_bit
        if (MASK[b]) begin : g_rw
            always_ff @(posedge clk) begin
                if (rst)
                    store_q[b] <= RESET_WORD[b];
                else if (wr_en)
                    store_q[b] <= wr_data[b];
            end
        end else begin : g_ro
            assign store_q[b] = 1'b0;
        end
    end

    assign word_q = store_q;
endmodule

// File: rtl/clkcfg_select.sv
module clkcfg_select
    import clkcfg_pkg::*;
(
    input  logic [REG_W-1:0]     word_q,
    input  logic [LEG_DIV_W-1:0] leg_div,
    input  logic                 leg_bypass,
    input  logic                 leg_pwrdn,
    input  logic [OSC_W-1:0]     leg_oscsel,
    output clk_cfg_t             eff_cfg,
    output logic                 use_osc
);
    clk_cfg_t ext_cfg;
    clk_cfg_t leg_cfg;

    always_comb begin
        ext_cfg = decode_word(word_q);
        leg_cfg = widen_legacy(leg_div, leg_bypass, leg_pwrdn, leg_oscsel);
        eff_cfg = word_q[OVR_BIT] ? ext_cfg : leg_cfg;
        use_osc = eff_cfg.bypass | eff_cfg.pwrdn;
    end
endmodule

// File: rtl/clkcfg_divider.sv
module clkcfg_divider
    import clkcfg_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             pll_tick,
    input  logic             osc_tick,
    input  logic             use_osc,
    input  logic [DIV_W-1:0] div_in,
    output logic             sys_en
);
    logic             src_tick;
    logic             half_q;
    logic [DIV_W-1:0] cnt_q;
    logic [DIV_W-1:0] div_act_q;
    logic             en_q;

    assign src_tick = use_osc ? osc_tick : pll_tick;

    always_ff @(posedge clk) begin
        if (rst) begin
            half_q    <= 1'b0;
            cnt_q     <= '0;
            div_act_q <= div_in;
            en_q      <= 1'b0;
        end else begin
            en_q <= 1'b0;
            if (src_tick) begin
                half_q <= ~half_q;
                if (half_q) begin
                    if (cnt_q == div_act_q) begin
                        cnt_q     <= '0;
                        div_act_q <= div_in;
                        en_q      <= 1'b1;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
            end
        end
    end

    assign sys_en = en_q;
endmodule

// File: rtl/clkcfg_ovr_top.sv
module clkcfg_ovr_top
    import clkcfg_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_en,
    input  logic [31:0] wr_data,
    output logic [31:0] rd_data,
    input  logic [3:0]  leg_div,
    input  logic        leg_bypass,
    input  logic        leg_pwrdn,
    input  logic [2:0]  leg_oscsel,
    input  logic        pll_tick,
    input  logic        osc_tick,
    output logic [2:0]  eff_oscsel,
    output logic        eff_bypass,
    output logic        eff_pwrdn,
    output logic        sys_en
);
    logic [REG_W-1:0] word_q;
    clk_cfg_t         eff_cfg;
    logic             use_osc;

    clkcfg_regfile u_reg (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .word_q  (word_q)
    );

    clkcfg_select u_sel (
        .word_q     (word_q),
        .leg_div    (leg_div),
        .leg_bypass (leg_bypass),
        .leg_pwrdn  (leg_pwrdn),
        .leg_oscsel (leg_oscsel),
        .eff_cfg    (eff_cfg),
        .use_osc    (use_osc)
    );

    clkcfg_divider u_div (
        .clk      (clk),
        .rst      (rst),
        .pll_tick (pll_tick),
        .osc_tick (osc_tick),
        .use_osc  (use_osc),
        .div_in   (eff_cfg.div),
        .sys_en   (sys_en)
    );

    assign rd_data    = word_q;
    assign eff_oscsel = eff_cfg.oscsel;
    assign eff_bypass = eff_cfg.bypass;
    assign eff_pwrdn  = eff_cfg.pwrdn;
endmodule

// File: rtl/clkcfg_chk.sv
module clkcfg_chk (
    input logic        clk,
    input logic        rst,
    input logic        wr_en,
    input logic [31:0] wr_data,
    input logic [31:0] rd_data,
    input logic        leg_bypass,
    input logic        leg_pwrdn,
    input logic [2:0]  leg_oscsel,
    input logic [2:0]  eff_oscsel,
    input logic        eff_bypass,
    input logic        eff_pwrdn,
    input logic        sys_en
);
    localparam logic [31:0] MASK = 32'h9F80_2870;

    AST_RESET_WORD: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> rd_data == 32'h0780_2810); // R1

    AST_WRITE_LATENCY: assert property (@(posedge clk) disable iff (rst)
        ($past(wr_en) && !$past(rst)) |-> rd_data == ($past(wr_data) & MASK)); // R2

    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (rst)
        (rd_data & ~MASK) == 32'h0); // R3

    AST_LEGACY_PATH: assert property (@(posedge clk) disable iff (rst)
        !rd_data[31] |-> (eff_oscsel == leg_oscsel && eff_bypass == leg_bypass
                          && eff_pwrdn == leg_pwrdn)); // R4

    AST_EXT_PATH: assert property (@(posedge clk) disable iff (rst)
        rd_data[31] |-> (eff_oscsel == rd_data[6:4] && eff_bypass == rd_data[11]
                         && eff_pwrdn == rd_data[13])); // R5

    AST_EN_SINGLE: assert property (@(posedge clk) disable iff (rst)
        sys_en |=> !sys_en); // R6
endmodule

bind clkcfg_ovr_top clkcfg_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (wr_en),
    .wr_data    (wr_data),
    .rd_data    (rd_data),
    .leg_bypass (leg_bypass),
    .leg_pwrdn  (leg_pwrdn),
    .leg_oscsel (leg_oscsel),
    .eff_oscsel (eff_oscsel),
    .eff_bypass (eff_bypass),
    .eff_pwrdn  (eff_pwrdn),
    .sys_en     (sys_en)
);

// File: tb/sim_clkcfg_ovr_top.sv
module sim_clkcfg_ovr_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic [3:0]  leg_div = 4'd3;
    logic        leg_bypass = 1'b0;
    logic        leg_pwrdn = 1'b0;
    logic [2:0]  leg_oscsel = 3'd2;
    logic        pll_tick = 1'b1;
    logic        osc_tick = 1'b0;
    logic [2:0]  eff_oscsel;
    logic        eff_bypass;
    logic        eff_pwrdn;
    logic        sys_en;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    always #2 clk = ~clk;

    clkcfg_ovr_top u0 (.*);

    // Oscillator tick: high every other cycle, changed away from the edge.
    initial forever begin
        @(negedge clk);
        osc_tick = ~osc_tick;
    end

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == 150000) begin
            fails++;
            checks++;
            $display("FAIL watchdog: run did not finish, actual %0d cycles expected fewer", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wait_pulse();
        do @(negedge clk); while (!sys_en);
    endtask

    task automatic period(output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!sys_en);
    endtask

    task automatic write_word(input logic [31:0] w);
        @(negedge clk);
        wr_en = 1'b1;
        wr_data = w;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    typedef struct packed {
        logic [31:0] wd;
        logic [3:0]  ldiv;
        logic        lbyp;
        logic        lpd;
        logic [2:0]  losc;
        logic [31:0] exp_rd;
        logic [2:0]  exp_osc;
        logic        exp_byp;
        logic        exp_pd;
        logic [15:0] exp_per;
    } vec_t;

    localparam int NV = 7;
    localparam vec_t VECS [NV] = '{
        '{32'h0000_0000, 4'd3,  1'b0, 1'b0, 3'd2, 32'h0000_0000, 3'd2, 1'b0, 1'b0, 16'd8},
        '{32'h8280_0050, 4'd9,  1'b1, 1'b1, 3'd0, 32'h8280_0050, 3'd5, 1'b0, 1'b0, 16'd12},
        '{32'hFFFF_FFFF, 4'd2,  1'b0, 1'b0, 3'd1, 32'h9F80_2870, 3'd7, 1'b1, 1'b1, 16'd256},
        '{32'h0000_2870, 4'd15, 1'b1, 1'b0, 3'd1, 32'h0000_2870, 3'd1, 1'b1, 1'b0, 16'd64},
        '{32'h8000_0000, 4'd7,  1'b1, 1'b1, 3'd6, 32'h8000_0000, 3'd0, 1'b0, 1'b0, 16'd2},
        '{32'h7FFF_FFFF, 4'd0,  1'b0, 1'b0, 3'd3, 32'h1F80_2870, 3'd3, 1'b0, 1'b0, 16'd2},
        '{32'h0000_0000, 4'd1,  1'b0, 1'b1, 3'd4, 32'h0000_0000, 3'd4, 1'b0, 1'b1, 16'd8}
    };

    initial begin
        int n;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset word, legacy path active
        chk(rd_data == 32'h0780_2810, "R1 reset word", rd_data, 32'h0780_2810);
        chk(eff_oscsel == 3'd2 && !eff_bypass && !eff_pwrdn, "R4 reset legacy select",
            {eff_oscsel, eff_bypass, eff_pwrdn}, {3'd2, 1'b0, 1'b0});
        wait_pulse();
        period(n);
        chk(n == 8, "R6 reset-state period legacy div 3", n, 8);

        // Vector table: R3 R4 R5 R6 R7 R9
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            leg_div = VECS[i].ldiv;
            leg_bypass = VECS[i].lbyp;
            leg_pwrdn = VECS[i].lpd;
            leg_oscsel = VECS[i].losc;
            wr_en = 1'b1;
            wr_data = VECS[i].wd;
            @(negedge clk);
            wr_en = 1'b0;
            chk(rd_data == VECS[i].exp_rd, "R2/R3 read after write", rd_data, VECS[i].exp_rd);
            chk({eff_oscsel, eff_bypass, eff_pwrdn} ==
                {VECS[i].exp_osc, VECS[i].exp_byp, VECS[i].exp_pd},
                "R4/R5 effective controls",
                {eff_oscsel, eff_bypass, eff_pwrdn},
                {VECS[i].exp_osc, VECS[i].exp_byp, VECS[i].exp_pd});
            wait_pulse();
            period(n);
            chk(n == int'(VECS[i].exp_per), "R6/R7/R9 enable period", n, VECS[i].exp_per);
        end

        // R2: one-cycle write latency, checked in the cycle right after the strobe
        write_word(32'h8A00_0830);
        chk(rd_data == 32'h8A00_0830, "R2 write visible next cycle", rd_data, 32'h8A00_0830);

        // R8: switch from divisor 63 to 0 just after a pulse; the old period must finish
        leg_bypass = 1'b0;
        leg_pwrdn = 1'b0;
        write_word(32'h9F80_0000);
        wait_pulse();
        period(n);
        chk(n == 128, "R9 register divisor 63 on PLL path", n, 128);
        wait_pulse();
        wr_en = 1'b1;
        wr_data = 32'h8000_0000;
        n = 0;
        do begin
            @(negedge clk);
            wr_en = 1'b0;
            n++;
        end while (!sys_en);
        chk(n == 128, "R8 old divisor completes its period", n, 128);
        period(n);
        chk(n == 2, "R8 new divisor used after terminal count", n, 2);

        // R5: legacy inputs ignored while the override is set
        leg_div = 4'd15;
        leg_bypass = 1'b1;
        leg_oscsel = 3'd7;
        wait_pulse();
        period(n);
        chk(n == 2 && eff_oscsel == 3'd0 && !eff_bypass, "R5 legacy change ignored",
            {n[7:0], eff_oscsel, eff_bypass}, {8'd2, 3'd0, 1'b0});

        // R1: reset again restores the reset word
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(rd_data == 32'h0780_2810, "R1 second reset", rd_data, 32'h0780_2810);

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule